// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This unit executes the eight integer multiply and divide operations of a 32-bit RISC-V core, one at a time, over several clock cycles. The core presents two operands and a 3-bit operation code with a one-cycle `start` strobe. The unit then raises `busy` for as long as it works and drops it when it finishes. At that moment it pulses `done` for one cycle and presents the result, which stays on `result` until the next operation completes.

Multiplication uses a shift-and-add loop that consumes one multiplier bit per cycle. A low-half product stops as soon as no set bits remain in the multiplier, so its latency depends on the operand. A high-half product always runs every bit position. Division uses a restoring long-division loop over operand magnitudes with a fixed latency. The one exception is a zero divisor, which finishes at once. Signed operations take the magnitudes of their operands, and the sign is corrected when the result is produced.

Top module: `iter_muldiv`

## Requirements
- R1: The operation code selects: 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU. MUL returns the low 32 bits of the product.
- R2: MULH returns the upper 32 bits of the signed x signed product. MULHSU returns the upper 32 bits of signed `a` times unsigned `b`. MULHU returns the upper 32 bits of the unsigned x unsigned product.
- R3: MUL keeps `busy` high for max(1, L) cycles, where L is the index of the highest set bit of `b` plus one.
- R4: MULH, MULHSU and MULHU keep `busy` high for exactly 32 cycles.
- R5: DIV and DIVU return the quotient rounded toward zero. REM and REMU return a remainder that takes the sign of the dividend.
- R6: With a zero divisor, the quotient is all ones and the remainder equals the dividend, and `busy` is high for exactly one cycle.
- R7: A signed division of 0x80000000 by -1 returns 0x80000000 as the quotient and 0 as the remainder.
- R8: A division or remainder with a nonzero divisor keeps `busy` high for exactly 37 cycles.
- R9: `done` is high for exactly one cycle, in the cycle right after `busy` falls. `result` holds its value until the next `done`.
- R10: A `start` pulse raised while `busy` is high is ignored. It changes neither the running result nor the latency.
- R11: After reset, `busy`, `done` and `result` are all zero.
- R12: A `start` raised in the same cycle as `done` is accepted, and `busy` rises on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code, see R1 |
| a | input | 32 | First operand / dividend |
| b | input | 32 | Second operand / multiplier / divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result of the last completed operation |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle, because the unit is idle again while `done` is high. The bench raises `start` with a new operation exactly in the `done` cycle. It then checks three things: the old result was presented intact, `busy` rises in the very next cycle, and the new operation returns its own value with its own expected latency. A second check sends a `start` during a running operation and confirms that neither the outcome nor the busy length changes.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } mdu_op_e;
endpackage

// File: rtl/mdu_shift_mult.sv
module mdu_shift_mult #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [1:0]   kind,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         active,
  output logic         fin,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W);

  logic [2*W-1:0] mcand, acc, acc_nx, prod_fix;
  logic [W-1:0]   mplier, a_mag, b_mag;
  logic [CW-1:0]  cnt;
  logic           neg, high, a_sgn, b_sgn;

  assign a_sgn = (kind == 2'd1) || (kind == 2'd2);
  assign b_sgn = (kind == 2'd1);
  assign a_mag = (a_sgn && a[W-1]) ? (~a + 1'b1) : a;
  assign b_mag = (b_sgn && b[W-1]) ? (~b + 1'b1) : b;

  assign acc_nx   = mplier[0] ? acc + mcand : acc;
  assign prod_fix = neg ? (~acc_nx + 1'b1) : acc_nx;
  assign fin      = active && (high ? (cnt == CW'(W-1)) : (mplier[W-1:1] == '0));
  assign res      = high ? prod_fix[2*W-1:W] : acc_nx[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      cnt    <= '0;
      neg    <= 1'b0;
      high   <= 1'b0;
    end else if (go) begin
      active <= 1'b1;
      mcand  <= {{W{1'b0}}, a_mag};
      mplier <= b_mag;
      acc    <= '0;
      cnt    <= '0;
      neg    <= (a_sgn & a[W-1]) ^ (b_sgn & b[W-1]);
      high   <= (kind != 2'd0);
    end else if (active) begin
      acc    <= acc_nx;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      cnt    <= cnt + 1'b1;
      if (fin) active <= 1'b0;
    end
  end

  // R3: a low-half multiply never spends a cycle past its first on an exhausted multiplier
  a_r3_no_idle_steps: assert property (@(posedge clk) disable iff (rst)
    (active && !high) |-> (mplier != '0 || cnt == '0));
endmodule

// File: rtl/mdu_long_div.sv
module mdu_long_div #(
  parameter int W      = 32,
  parameter int CYCLES = 37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         want_rem,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         active,
  output logic         fin,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [W-1:0]  quo, rem, den, dvd, a_mag, b_mag, q_out, r_out;
  logic [W:0]    trial, diff;
  logic [CW-1:0] cnt;
  logic          qneg, rneg, dz, rsel, ge;

  assign a_mag = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
  assign b_mag = (is_signed && b[W-1]) ? (~b + 1'b1) : b;

  assign trial = {rem, quo[W-1]};
  assign ge    = trial >= {1'b0, den};
  assign diff  = trial - {1'b0, den};

  assign q_out = qneg ? (~quo + 1'b1) : quo;
  assign r_out = rneg ? (~rem + 1'b1) : rem;
  assign fin   = active && (dz || cnt == CW'(CYCLES-1));
  assign res   = dz ? (rsel ? dvd : '1) : (rsel ? r_out : q_out);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      quo    <= '0;
      rem    <= '0;
      den    <= '0;
      dvd    <= '0;
      cnt    <= '0;
      qneg   <= 1'b0;
      rneg   <= 1'b0;
      dz     <= 1'b0;
      rsel   <= 1'b0;
    end else if (go) begin
      active <= 1'b1;
      quo    <= a_mag;
      rem    <= '0;
      den    <= b_mag;
      dvd    <= a;
      cnt    <= '0;
      qneg   <= is_signed & (a[W-1] ^ b[W-1]);
      rneg   <= is_signed & a[W-1];
      dz     <= (b == '0);
      rsel   <= want_rem;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (cnt < CW'(W)) begin
        quo <= {quo[W-2:0], ge};
        rem <= ge ? diff[W-1:0] : trial[W-1:0];
      end
      if (fin) active <= 1'b0;
    end
  end

  // R6: a zero divisor finishes in the first busy cycle
  a_r6_zero_div_fast: assert property (@(posedge clk) disable iff (rst)
    (go && b == '0) |=> fin);
  // R8: a nonzero divisor never finishes in the first busy cycle
  a_r8_full_division: assert property (@(posedge clk) disable iff (rst)
    (go && b != '0) |=> (active && !fin));
endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv #(
  parameter int W          = 32,
  parameter int DIV_CYCLES = 37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  import mdu_pkg::*;

  mdu_op_e      op_e;
  logic         take, mul_go, div_go;
  logic         mul_act, mul_fin, div_act, div_fin;
  logic [W-1:0] mul_res, div_res;

  assign op_e   = mdu_op_e'(op);
  assign take   = start && !busy;
  assign mul_go = take && !op_e[2];
  assign div_go = take && op_e[2];

  mdu_shift_mult #(.W(W)) u_mult (
    .clk(clk), .rst(rst), .go(mul_go), .kind(op[1:0]),
    .a(a), .b(b), .active(mul_act), .fin(mul_fin), .res(mul_res)
  );

  mdu_long_div #(.W(W), .CYCLES(DIV_CYCLES)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .want_rem(op[1]), .is_signed(!op[0]),
    .a(a), .b(b), .active(div_act), .fin(div_fin), .res(div_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= mul_fin | div_fin;
      if (mul_fin)      result <= mul_res;
      else if (div_fin) result <= div_res;
      if (take)                   busy <= 1'b1;
      else if (mul_fin | div_fin) busy <= 1'b0;
    end
  end

  // R9: completion pulse lasts one cycle and only once the unit is idle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R12: a start while idle (including the done cycle) is taken
  a_r12_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R10: only one engine ever runs at a time
  a_r10_one_engine: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mul_act, div_act}));
  // R10: result is frozen while an operation runs
  a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(result));
endmodule

// File: tb/iter_muldiv_test.sv
module iter_muldiv_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic [31:0] a, b;
  logic        busy, done;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  iter_muldiv uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] model_res(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic signed [63:0] p;
    logic [63:0] u;
    case (o)
      3'd0: begin u = {32'h0, x} * {32'h0, y}; return u[31:0]; end
      3'd1: begin p = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y}); return p[63:32]; end
      3'd2: begin p = $signed({{32{x[31]}}, x}) * $signed({32'h0, y}); return p[63:32]; end
      3'd3: begin u = {32'h0, x} * {32'h0, y}; return u[63:32]; end
      3'd4: begin
        if (y == 0) return 32'hFFFF_FFFF;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return x;
        return $signed(x) / $signed(y);
      end
      3'd5: return (y == 0) ? 32'hFFFF_FFFF : x / y;
      3'd6: begin
        if (y == 0) return x;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'h0;
        return $signed(x) % $signed(y);
      end
      default: return (y == 0) ? x : x % y;
    endcase
  endfunction

  function automatic int model_lat(input logic [2:0] o, input logic [31:0] y);
    int l;
    if (o == 3'd0) begin
      l = 1;
      for (int i = 0; i < 32; i++) if (y[i]) l = i + 1;
      return l;
    end
    if (o < 3'd4) return 32;
    return (y == 0) ? 1 : 37;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // wait out busy at negedges, counting the cycles busy is observed high
  task automatic wait_busy(output int lat);
    lat = 0;
    while (busy && lat < 200) begin
      lat++;
      @(negedge clk);
    end
  endtask

  // one full operation: result, latency, done width
  task automatic run_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input string req);
    int lat;
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    wait_busy(lat);
    check(done === 1'b1 && result === model_res(o, x, y), req, result, model_res(o, x, y));
    check(lat == model_lat(o, y), {req, " latency"}, lat, model_lat(o, y));
    @(negedge clk);
    check(done === 1'b0 && result === model_res(o, x, y), "R9 done single/result held", {31'b0, done}, 32'h0);
  endtask

  task automatic test_reset();
    rst = 1'b1; start = 1'b0; op = 3'd0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && result === 32'h0, "R11 reset state",
          {busy, done, result[29:0]}, 32'h0);
  endtask

  task automatic test_mul_low();
    run_op(3'd0, 32'd7, 32'd0, "R1 R3 MUL b=0");
    run_op(3'd0, 32'h1234_5678, 32'd1, "R1 R3 MUL b=1");
    run_op(3'd0, 32'hFFFF_FFFD, 32'd5, "R1 R3 MUL b=5");
    run_op(3'd0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R1 R3 MUL b=all ones");
    run_op(3'd0, 32'h0000_0003, 32'h8000_0000, "R1 R3 MUL b=msb");
  endtask

  task automatic test_mul_high();
    run_op(3'd1, 32'hFFFF_FFFE, 32'h0000_0003, "R2 R4 MULH neg*pos");
    run_op(3'd1, 32'h8000_0000, 32'h8000_0000, "R2 R4 MULH min*min");
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R4 MULHSU");
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R4 MULHU");
    run_op(3'd3, 32'h1234_5678, 32'd0, "R2 R4 MULHU b=0");
  endtask

  task automatic test_div();
    run_op(3'd4, 32'hFFFF_FFF9, 32'd2, "R5 R8 DIV -7/2");
    run_op(3'd6, 32'hFFFF_FFF9, 32'd2, "R5 R8 REM -7%2");
    run_op(3'd4, 32'd7, 32'hFFFF_FFFE, "R5 R8 DIV 7/-2");
    run_op(3'd6, 32'd7, 32'hFFFF_FFFE, "R5 R8 REM 7%-2");
    run_op(3'd5, 32'hFFFF_FFF9, 32'd2, "R5 R8 DIVU");
    run_op(3'd7, 32'hFFFF_FFF9, 32'd10, "R5 R8 REMU");
  endtask

  task automatic test_div_zero();
    run_op(3'd4, 32'h8765_4321, 32'd0, "R6 DIV by zero");
    run_op(3'd5, 32'd99, 32'd0, "R6 DIVU by zero");
    run_op(3'd6, 32'h8765_4321, 32'd0, "R6 REM by zero");
    run_op(3'd7, 32'd99, 32'd0, "R6 REMU by zero");
  endtask

  task automatic test_overflow();
    run_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, "R7 DIV overflow");
    run_op(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, "R7 REM overflow");
  endtask

  // R10: a start raised mid-operation must not disturb it
  task automatic test_ignore_start();
    int lat;
    @(negedge clk);
    start = 1'b1; op = 3'd5; a = 32'd1000; b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; op = 3'd0; a = 32'd3; b = 32'd3;
    @(negedge clk);
    start = 1'b0;
    wait_busy(lat);
    check(done === 1'b1 && result === 32'd142, "R10 busy start ignored result", result, 32'd142);
    check(lat == 37 - 4, "R10 busy start ignored latency", lat + 4, 32'd37);
    @(negedge clk);
    check(busy === 1'b0, "R10 no phantom op", {31'b0, busy}, 32'h0);
  endtask

  // R12: new start in the done cycle
  task automatic test_back_to_back();
    int lat;
    @(negedge clk);
    start = 1'b1; op = 3'd0; a = 32'd6; b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    wait_busy(lat);
    check(done === 1'b1 && result === 32'd42, "R12 first result", result, 32'd42);
    start = 1'b1; op = 3'd7; a = 32'd0; b = 32'd0;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0 && result === 32'd42, "R12 accepted in done cycle",
          {busy, done, result[29:0]}, {2'b10, 30'd42});
    wait_busy(lat);
    check(done === 1'b1 && result === 32'd0 && lat == 1, "R12 second result", result, 32'd0);
  endtask

  initial begin
    test_reset();
    test_mul_low();
    test_mul_high();
    test_div();
    test_div_zero();
    test_overflow();
    test_ignore_start();
    test_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule